// File: doc/BRIEF.md
# Transmit Squelch Qualifier

This block decides when the transmit path carries real data rather than noise. Its input is a single flag, `neg_exc`. It is sampled on a fast clock and goes high while the differential transmit input is more negative than the squelch threshold. The threshold comparison happens before this block. Only that polarity is ever presented, so a positive excursion cannot turn the transmitter on.

The qualifier applies time hysteresis on both edges:

- **Turn-on:** it requires a run of consecutive flagged samples before it declares the transmitter active. Any low sample clears a partial run.
- **Turn-off:** once active, it stays active until no flagged sample has been seen for a sustained gap. Every flagged sample during a packet restarts that gap count.

The resulting `tx_active` feeds the jabber timer and the heartbeat generator. `drv_en` is the actual cable driver enable, and the jabber inhibit forces it off. The inhibit leaves `tx_active` alone, so the jabber logic still sees when the packet really ends.

Default thresholds assume a 200 MHz sample clock:

- `ON_CYCLES` = 3 samples, about 15 ns of sustained excursion before turn-on.
- `GAP_CYCLES` = 50 samples, about 250 ns of quiet before turn-off.

Because of the turn-on delay, the first transmitted bit may be partly lost.

Top module: `tx_squelch_qual`

## Requirements
- R1: While `rst_n` is low and after its release, `tx_active` and `drv_en` are 0 until a qualifying run is seen.
- R2: When idle, `tx_active` goes to 1 at the rising clock edge that samples the `ON_CYCLES`-th consecutive high `neg_exc`.
- R3: When idle, a run of fewer than `ON_CYCLES` high samples does not assert `tx_active`. A single low sample restarts the count from zero.
- R4: While active, `tx_active` stays 1 across any run of fewer than `GAP_CYCLES` consecutive low samples of `neg_exc`.
- R5: While active, `tx_active` goes to 0 at the edge that samples the `GAP_CYCLES`-th consecutive low `neg_exc`.
- R6: While active, every high sample of `neg_exc` restarts the gap count, so the `GAP_CYCLES` low run is measured from the last high sample.
- R7: `drv_en` is 1 exactly when `tx_active` is 1 and `jab_inhibit` is 0, with no added clock delay.
- R8: `jab_inhibit` has no effect on `tx_active`, on its turn-on time or on its turn-off time.
- R9: After turn-off, turning on again requires a fresh run of `ON_CYCLES` consecutive high samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| neg_exc | input | 1 | High while the transmit input is beyond the negative squelch threshold |
| jab_inhibit | input | 1 | Jabber inhibit; forces the driver enable off |
| tx_active | output | 1 | Qualified transmit activity |
| drv_en | output | 1 | Cable driver enable |

## Verification
The hardest case to reach is a gap that ends one sample before the timeout, followed by a single high sample. That sample must restart the full gap count. Random bursts seldom produce a low run of exactly `GAP_CYCLES-1`. Directed sequences therefore build gaps of exactly 49 and 50 samples, runs of exactly 2 and 3 high samples, and jabber pulses placed inside a packet. A long random phase then mixes run lengths that straddle both thresholds, with jabber toggling independently.

// File: rtl/tx_squelch_qual.sv
module tx_squelch_qual #(
  parameter int ON_CYCLES  = 3,
  parameter int GAP_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_exc,
  input  logic jab_inhibit,
  output logic tx_active,
  output logic drv_en
);

  localparam int OW = $clog2(ON_CYCLES + 1);
  localparam int GW = $clog2(GAP_CYCLES + 1);
  localparam logic [OW-1:0] ON_LAST  = OW'(ON_CYCLES - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

  logic [OW-1:0] on_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active <= 1'b0;
      on_cnt    <= '0;
      gap_cnt   <= '0;
    end else if (!tx_active) begin
      if (!neg_exc) begin
        on_cnt <= '0;
      end else if (on_cnt == ON_LAST) begin
        tx_active <= 1'b1;
        on_cnt    <= '0;
        gap_cnt   <= '0;
      end else begin
        on_cnt <= on_cnt + 1'b1;
      end
    end else begin
      if (neg_exc) begin
        gap_cnt <= '0;
      end else if (gap_cnt == GAP_LAST) begin
        tx_active <= 1'b0;
        gap_cnt   <= '0;
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  assign drv_en = tx_active & ~jab_inhibit;

  a_r2_rise_on_excursion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(neg_exc));

  a_r3_quiet_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !neg_exc) |=> !tx_active);

  a_r5_fall_on_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> !$past(neg_exc));

  a_r6_excursion_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && neg_exc) |=> tx_active);

  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    jab_inhibit |-> !drv_en);

endmodule

// File: tb/tx_squelch_qual_tb_top.sv
module tx_squelch_qual_tb_top;
  localparam int ON  = 3;
  localparam int GAP = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic neg_exc = 1'b0;
  logic jab_inhibit = 1'b0;
  logic tx_active, drv_en;

  int n_chk = 0, n_fail = 0;
  bit m_act = 1'b0;
  int m_hi = 0, m_lo = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_squelch_qual #(.ON_CYCLES(ON), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .neg_exc(neg_exc), .jab_inhibit(jab_inhibit),
    .tx_active(tx_active), .drv_en(drv_en));

  function automatic bit exp_drv(bit act, bit jab);
    return act && !jab;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit x, bit jab, string tag);
    @(negedge clk);
    neg_exc = x;
    jab_inhibit = jab;
    if (!m_act) begin
      m_hi = x ? m_hi + 1 : 0;
      if (m_hi >= ON) begin m_act = 1'b1; m_hi = 0; m_lo = 0; end
    end else begin
      m_lo = x ? 0 : m_lo + 1;
      if (m_lo >= GAP) begin m_act = 1'b0; m_lo = 0; end
    end
    @(posedge clk);
    #3;
    check(tag, tx_active, m_act);
    check("R7", drv_en, exp_drv(m_act, jab));
  endtask

  task automatic run(bit x, int n, bit jab, string tag);
    for (int i = 0; i < n; i++) step(x, jab, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    neg_exc = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    check("R1", tx_active, 1'b0);
    check("R1", drv_en, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    neg_exc = 1'b0;
    m_hi = 0;
    run(0, 4, 0, "R1");
    run(1, 2, 0, "R3");
    run(0, 1, 0, "R3");
    run(1, 2, 0, "R3");
    run(0, 2, 0, "R3");
    run(1, 3, 0, "R2");
    check("R2", tx_active, 1'b1);
    run(0, GAP - 1, 0, "R4");
    run(1, 1, 0, "R6");
    run(0, GAP - 1, 0, "R6");
    check("R6", tx_active, 1'b1);
    run(0, 1, 0, "R5");
    check("R5", tx_active, 1'b0);
    run(1, 2, 0, "R9");
    check("R9", tx_active, 1'b0);
    run(1, 1, 0, "R9");
    run(1, 5, 1, "R8");
    check("R8", tx_active, 1'b1);
    check("R7", drv_en, 1'b0);
    run(0, GAP - 1, 1, "R8");
    run(0, 1, 0, "R8");
    check("R8", tx_active, 1'b0);
    run(1, 3, 1, "R8");
    check("R8", tx_active, 1'b1);
    run(0, GAP, 0, "R5");
    for (int k = 0; k < 400; k++) begin
      bit x = k[0];
      int len = x ? 1 + int'($urandom_range(4)) : 1 + int'($urandom_range(GAP + 8));
      for (int j = 0; j < len; j++) step(x, $urandom_range(3) == 0, "R2R5");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule